// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that finishes one instruction in every clock cycle. It executes nine instructions: word load, word store, add, subtract, AND, OR, signed set-less-than, branch-if-equal and an absolute jump. The program counter, a 32-entry register file with two operand read ports and one write port, the ALU, immediate sign extension and both next-PC targets are inside the core. Instruction storage and data storage are two separate internal arrays, so an instruction fetch and a data access can happen in the same cycle.

While reset is held, software or a testbench fills either array through a word-addressed write port. Once reset is released the core runs from address 0. A debug port returns the current PC, any register and any data word, all combinationally. Register and memory reads are combinational and writes take effect on the rising edge, so each instruction sees the results of the one before it.

Top module: `uniproc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and clears all 32 registers at each rising edge where it is high. While `rst` is high the core writes neither registers nor data memory.
- R2: The PC advances by 4 on each clock edge unless a branch or jump is taken. The instruction word is taken from instruction memory at word index PC[IAW+1:2], which wraps modulo the array size.
- R3: An R-type instruction (opcode [31:26] = 0) reads rs [25:21] and rt [20:16] and writes rd [15:11]. The operation is set by funct [5:0]: 32 gives add, 34 subtract, 36 AND, 37 OR and 42 set-less-than. Add and subtract wrap modulo 2^32. Shamt [10:6] has no effect, and any other funct value writes nothing.
- R4: Set-less-than writes 1 when rs is less than rt compared as signed two's-complement numbers, and 0 otherwise.
- R5: A load (opcode 35) writes data word (rs + sign-extended imm[15:0]) >> 2 into register rt. The next instruction can read that value.
- R6: A store (opcode 43) writes register rt into data word (rs + sign-extended imm) >> 2 and writes no register. A store and the next fetch can use the same word index without affecting each other.
- R7: A branch-equal (opcode 4) whose rs and rt values are equal sets the PC to PC+4 plus (sign-extended imm shifted left by 2). When the values differ the PC moves to PC+4. A branch writes no register.
- R8: A jump (opcode 2) sets the PC to {PC[31:28], instr[25:0], 2'b00}.
- R9: Register 0 always reads as 0, and a write to register 0 by an R-type or a load has no effect.
- R10: Any other opcode is a no-op. It writes no register and no data word, and the PC moves to PC+4.
- R11: When `ld_we` is high, `ld_data` is written at the next rising edge to word `ld_addr` of data memory if `ld_dmem` = 1, or of instruction memory if `ld_dmem` = 0. `dbg_pc`, `dbg_reg_val` (register `dbg_reg_sel`) and `dbg_mem_val` (data word `dbg_mem_sel`) show the current state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 selects data memory, 0 selects instruction memory |
| ld_addr | input | LAW (8) | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_sel | input | DAW (8) | Data memory word index to observe |
| dbg_mem_val | output | 32 | Value of the selected data word |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a store and the instruction fetch. The bench places a store at instruction word 7 that targets data word 8. The next cycle fetches instruction word 8, and it must still run as the original add while data word 8 holds the stored value. The second pair is a register write from a load and an operand read of that register by the next instruction. Every ALU sweep case loads two operands and uses them at once, then stores the result and reads it back at once. The bench checks the resulting register, data word and final PC against values it computes arithmetically for all 320 operand and operation combinations.

// File: rtl/uniproc_pkg.sv
package uniproc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic    rf_we;
        logic    dst_is_rd;
        logic    wb_from_mem;
        logic    dm_we;
        logic    b_is_imm;
        logic    is_branch;
        logic    is_jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/uniproc_decode.sv
module uniproc_decode
    import uniproc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{rf_we: 1'b0, dst_is_rd: 1'b0, wb_from_mem: 1'b0, dm_we: 1'b0,
                 b_is_imm: 1'b0, is_branch: 1'b0, is_jump: 1'b0, alu_op: ALU_ADD};
        case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.rf_we     = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.rf_we  = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.rf_we       = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.b_is_imm    = 1'b1;
            end
            OPC_STORE: begin
                ctrl.dm_we    = 1'b1;
                ctrl.b_is_imm = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OPC_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/uniproc_alu.sv
module uniproc_alu
    import uniproc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] diff;

    always_comb begin
        diff = a - b;
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/uniproc_regfile.sv
module uniproc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);

    logic [W-1:0] regs_d [NREGS];
    logic [W-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs_q[raddr[p]];
    end

endmodule

// File: rtl/uniproc_ram.sv
module uniproc_ram #(
    parameter int WORDS = 256,
    parameter int W     = 32,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);

    logic [W-1:0] mem_d [WORDS];
    logic [W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end

endmodule

// File: rtl/uniproc_core.sv
module uniproc_core
    import uniproc_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 256,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic            ld_dmem,
    input  logic [LAW-1:0]  ld_addr,
    input  logic [31:0]     ld_data,
    output logic [31:0]     dbg_pc,
    input  logic [4:0]      dbg_reg_sel,
    output logic [31:0]     dbg_reg_val,
    input  logic [DAW-1:0]  dbg_mem_sel,
    output logic [31:0]     dbg_mem_val
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [XLEN-1:0] instr;
    logic [5:0]      f_op;
    logic [4:0]      f_rs, f_rt, f_rd;
    logic [5:0]      f_fn;
    logic [15:0]     f_imm;
    ctrl_t           ctrl;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] pc_plus4, br_target, jmp_target;

    logic            rf_we;
    logic [4:0]      rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic [XLEN-1:0] dm_rdata;
    logic            core_dm_we;

    logic            im_we;
    logic [IAW-1:0]  im_raddr [1];
    logic [XLEN-1:0] im_rdata [1];

    logic            dm_we;
    logic [DAW-1:0]  dm_waddr;
    logic [XLEN-1:0] dm_wdata;
    logic [DAW-1:0]  dm_raddr [2];
    logic [XLEN-1:0] dm_rdata_v [2];

    logic [4:0]      rf_raddr [3];
    logic [XLEN-1:0] rf_rdata [3];

    // field split of the fetched word
    always_comb begin
        instr  = im_rdata[0];
        f_op   = instr[31:26];
        f_rs   = instr[25:21];
        f_rt   = instr[20:16];
        f_rd   = instr[15:11];
        f_fn   = instr[5:0];
        f_imm  = instr[15:0];
    end

    uniproc_decode u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .ctrl   (ctrl)
    );

    assign rf_raddr[0] = f_rs;
    assign rf_raddr[1] = f_rt;
    assign rf_raddr[2] = dbg_reg_sel;

    uniproc_regfile #(.NREGS(32), .W(XLEN), .NRD(3)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    assign rs_val      = rf_rdata[0];
    assign rt_val      = rf_rdata[1];
    assign dbg_reg_val = rf_rdata[2];

    uniproc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // datapath and next-state computation
    always_comb begin
        imm_ext    = {{(XLEN-16){f_imm[15]}}, f_imm};
        alu_b      = ctrl.b_is_imm ? imm_ext : rt_val;
        pc_plus4   = st_q.pc + 32'd4;
        br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        jmp_target = {st_q.pc[31:28], instr[25:0], 2'b00};

        rf_we      = ctrl.rf_we & ~rst;
        rf_waddr   = ctrl.dst_is_rd ? f_rd : f_rt;
        rf_wdata   = ctrl.wb_from_mem ? dm_rdata : alu_y;
        core_dm_we = ctrl.dm_we & ~rst;

        st_d = st_q;
        if (ctrl.is_jump) begin
            st_d.pc = jmp_target;
        end else if (ctrl.is_branch && alu_zero) begin
            st_d.pc = br_target;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_pc = st_q.pc;

    // instruction memory: written only by the preload port
    assign im_we       = ld_we & ~ld_dmem;
    assign im_raddr[0] = st_q.pc[IAW+1:2];

    uniproc_ram #(.WORDS(IMEM_WORDS), .W(XLEN), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_data),
        .raddr (im_raddr),
        .rdata (im_rdata)
    );

    // data memory: preload port has priority over core stores
    always_comb begin
        if (ld_we && ld_dmem) begin
            dm_we    = 1'b1;
            dm_waddr = ld_addr[DAW-1:0];
            dm_wdata = ld_data;
        end else begin
            dm_we    = core_dm_we;
            dm_waddr = alu_y[DAW+1:2];
            dm_wdata = rt_val;
        end
        dm_raddr[0] = alu_y[DAW+1:2];
        dm_raddr[1] = dbg_mem_sel;
    end

    uniproc_ram #(.WORDS(DMEM_WORDS), .W(XLEN), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata_v)
    );

    assign dm_rdata    = dm_rdata_v[0];
    assign dbg_mem_val = dm_rdata_v[1];

endmodule

// File: rtl/uniproc_chk.sv
module uniproc_chk
    import uniproc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [4:0]  dbg_sel,
    input logic [31:0] dbg_val
);

    logic [5:0]  op;
    logic        op_known;
    logic [31:0] br_ofs;

    always_comb begin
        op       = instr[31:26];
        op_known = (op == OPC_RTYPE) || (op == OPC_JUMP) || (op == OPC_BEQ) ||
                   (op == OPC_LOAD)  || (op == OPC_STORE);
        br_ofs   = {{14{instr[15]}}, instr[15:0], 2'b00};
    end

    // R1: reset returns the PC to zero
    p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc == 32'd0));

    // R2: sequential advance when no transfer is taken
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        ((op != OPC_JUMP) && !((op == OPC_BEQ) && (rs_val == rt_val)))
        |=> (pc == $past(pc) + 32'd4));

    // R7: taken branch target
    p_beq_target_r7: assert property (@(posedge clk) disable iff (rst)
        ((op == OPC_BEQ) && (rs_val == rt_val))
        |=> (pc == $past(pc) + 32'd4 + $past(br_ofs)));

    // R8: jump target concatenation
    p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JUMP)
        |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    // R9: register zero reads as zero
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == 5'd0) |-> (dbg_val == 32'd0));

    // R6: a store writes memory and no register
    p_store_only_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_STORE) |-> (dm_we && !rf_we));

    // R10: unknown opcodes touch no state
    p_nop_r10: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> (!rf_we && !dm_we));

endmodule

bind uniproc_core uniproc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (dbg_pc),
    .instr   (instr),
    .rf_we   (rf_we),
    .dm_we   (core_dm_we),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .dbg_sel (dbg_reg_sel),
    .dbg_val (dbg_reg_val)
);

// File: tb/uniproc_core_tb_top.sv
`timescale 1ns/1ps
module uniproc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_val;
    logic [7:0]  dbg_mem_sel = '0;
    logic [31:0] dbg_mem_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uniproc_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .ld_we       (ld_we),
        .ld_dmem     (ld_dmem),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .dbg_pc      (dbg_pc),
        .dbg_reg_sel (dbg_reg_sel),
        .dbg_reg_val (dbg_reg_val),
        .dbg_mem_sel (dbg_mem_sel),
        .dbg_mem_val (dbg_mem_val)
    );

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd,
                                          input logic [4:0] sh);
        return {6'd0, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] a);
        return {6'd2, a};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic sel, input int addr, input logic [31:0] data);
        ld_we   = 1'b1;
        ld_dmem = sel;
        ld_addr = addr[7:0];
        ld_data = data;
        @(negedge clk);
        ld_we   = 1'b0;
    endtask

    task automatic start_reset();
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_is(input string tag, input int idx, input logic [31:0] exp);
        dbg_reg_sel = idx[4:0];
        #0.1;
        check(tag, dbg_reg_val, exp);
    endtask

    task automatic mem_is(input string tag, input int idx, input logic [31:0] exp);
        dbg_mem_sel = idx[7:0];
        #0.1;
        check(tag, dbg_mem_val, exp);
    endtask

    function automatic logic [31:0] opnd(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0005;
            4: return 32'hFFFF_FFF9;
            5: return 32'h7FFF_FFFF;
            6: return 32'h8000_0000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [5:0]  fns [5];
        logic [31:0] a, b, e;
        fns[0] = 6'd32; fns[1] = 6'd34; fns[2] = 6'd36; fns[3] = 6'd37; fns[4] = 6'd42;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pc during reset", dbg_pc, 32'd0);
        reg_is("R1 reg cleared", 7, 32'd0);

        // R3 R4 R5 R6: ALU sweep through load/op/store/reload
        for (int f = 0; f < 5; f++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    a = opnd(i);
                    b = opnd(j);
                    case (f)
                        0: e = a + b;
                        1: e = a - b;
                        2: e = a & b;
                        3: e = a | b;
                        default: e = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    endcase
                    start_reset();
                    load(1'b1, 0, a);
                    load(1'b1, 1, b);
                    load(1'b0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
                    load(1'b0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd4));
                    load(1'b0, 2, enc_r(fns[f], 5'd1, 5'd2, 5'd3, 5'd31));
                    load(1'b0, 3, enc_i(6'd43, 5'd0, 5'd3, 16'd8));
                    load(1'b0, 4, enc_i(6'd35, 5'd0, 5'd4, 16'd8));
                    load(1'b0, 5, enc_j(26'd5));
                    run(6);
                    if (f == 4) reg_is("R4 slt result", 3, e);
                    else        reg_is("R3 alu result", 3, e);
                    mem_is("R6 stored word", 2, e);
                    reg_is("R5 reload after store", 4, e);
                    check("R2 pc after sequence", dbg_pc, 32'd20);
                end
            end
        end

        // R7 R8: branches and jump with upper PC bits
        start_reset();
        load(1'b1, 0, 32'd7);
        load(1'b1, 1, 32'd7);
        load(1'b1, 2, 32'd9);
        load(1'b0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
        load(1'b0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd4));
        load(1'b0, 2, enc_i(6'd35, 5'd0, 5'd3, 16'd8));
        load(1'b0, 3, enc_i(6'd4, 5'd1, 5'd3, 16'd5));
        load(1'b0, 4, enc_i(6'd4, 5'd1, 5'd2, 16'd2));
        load(1'b0, 5, enc_r(6'd32, 5'd1, 5'd1, 5'd5, 5'd0));
        load(1'b0, 6, enc_r(6'd32, 5'd1, 5'd1, 5'd5, 5'd0));
        load(1'b0, 7, enc_i(6'd4, 5'd0, 5'd0, 16'hFFF7));
        load(1'b0, 255, enc_j(26'd9));
        load(1'b0, 9, enc_r(6'd32, 5'd1, 5'd2, 5'd7, 5'd0));
        load(1'b0, 10, enc_j(26'd10));
        run(3);
        check("R2 pc after loads", dbg_pc, 32'd12);
        run(1);
        check("R7 branch not taken", dbg_pc, 32'd16);
        run(1);
        check("R7 branch forward taken", dbg_pc, 32'd28);
        run(1);
        check("R7 branch backward wraps", dbg_pc, 32'hFFFF_FFFC);
        run(1);
        check("R8 jump keeps upper bits", dbg_pc, 32'hF000_0024);
        run(1);
        check("R8 jump self loop", dbg_pc, 32'hF000_0028);
        reg_is("R8 target instruction ran", 7, 32'd14);
        reg_is("R7 skipped instructions", 5, 32'd0);
        run(2);
        check("R8 self loop holds", dbg_pc, 32'hF000_0028);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc after mid-run reset", dbg_pc, 32'd0);
        reg_is("R1 regs after mid-run reset", 7, 32'd0);

        // R9 R10 R3 R6: zero register, no-ops, store beside fetch
        start_reset();
        load(1'b1, 0, 32'd16);
        load(1'b1, 1, 32'h0000_0055);
        load(1'b1, 3, 32'hABCD_0001);
        load(1'b1, 8, 32'h0000_0000);
        load(1'b0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
        load(1'b0, 1, enc_i(6'd35, 5'd1, 5'd2, 16'hFFFC));
        load(1'b0, 2, enc_r(6'd32, 5'd1, 5'd2, 5'd0, 5'd0));
        load(1'b0, 3, enc_i(6'd35, 5'd0, 5'd0, 16'd0));
        load(1'b0, 4, enc_i(6'h3F, 5'd0, 5'd1, 16'd4));
        load(1'b0, 5, enc_i(6'd8, 5'd1, 5'd3, 16'd5));
        load(1'b0, 6, enc_r(6'd39, 5'd1, 5'd2, 5'd3, 5'd0));
        load(1'b0, 7, enc_i(6'd43, 5'd0, 5'd2, 16'd32));
        load(1'b0, 8, enc_r(6'd32, 5'd1, 5'd1, 5'd4, 5'd0));
        load(1'b0, 9, enc_j(26'd9));
        run(5);
        check("R10 pc after unknown op", dbg_pc, 32'd20);
        run(1);
        check("R10 pc after second unknown op", dbg_pc, 32'd24);
        run(1);
        check("R3 pc after unknown funct", dbg_pc, 32'd28);
        run(3);
        check("R6 pc after store and fetch", dbg_pc, 32'd36);
        reg_is("R9 reg zero reads zero", 0, 32'd0);
        reg_is("R5 load base", 1, 32'd16);
        reg_is("R5 negative offset load", 2, 32'hABCD_0001);
        reg_is("R10 no-op wrote no register", 3, 32'd0);
        mem_is("R10 no-op wrote no memory", 1, 32'h0000_0055);
        mem_is("R6 store beside fetch", 8, 32'hABCD_0001);
        reg_is("R6 fetched word intact", 4, 32'd32);
        mem_is("R11 preloaded word", 0, 32'd16);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule